// File: doc/BRIEF.md
# Clock Controller Register Block

This block is the configuration store of a clock control unit. It sits behind a 32-bit APB-style slave port and keeps the settings that software programs for the chip's phase-locked loops, bus dividers, memory clock setup, bus reset and PLL settle timers. Each named register comes out of reset with its own value. The block drives no clocks itself. It only stores words and returns them.

Two registers change what is written to them. On a PLL control register, setting the enable bit makes the lock flag read back as set at once, so that driver code polling for lock finishes without a real loop. On the memory clock configuration register, the update-request bit never sticks. The register window goes past the last implemented word. The tail of the window reads as zero and drops writes.

Accesses are zero-wait-state. A write takes effect on the clock edge of its access phase. Read data is driven combinationally during a selected read. Only whole 32-bit words are transferred, and there are no byte strobes.

Top module: `clkctl_regs`

## Requirements
- R1: After reset, the registers hold these values. PLL words at 0x00 and 0x20 hold 0x00001000. PLL words at 0x10, 0x18, 0x38 and 0x48 hold 0x03006207. The word at 0x08 holds 0x00035514. The words at 0x28 and 0x44 hold 0x00041811. 0x50 holds 0x00010000, 0x54 holds 0x00001010 and 0x58 holds 0x01000000. 0xF4 holds 0. 0xFC holds 0x80000000. 0x200 and 0x204 hold 0x000000FF. 0x220 holds 0x08100200 and 0x230 holds 0x81104000. 0x234 and 0x244 hold 0x10100010. 0x224, 0x228, 0x22C, 0x23C and 0x248 hold 0x10100000. 0x250 holds 0x0A101000 and 0x260 holds 0x14880000.
- R2: A write with bit 31 set to any of the nine PLL words (0x00, 0x08, 0x10, 0x18, 0x20, 0x28, 0x38, 0x44, 0x48) stores the data with bit 28 forced to 1. All other bits are stored as written.
- R3: A write with bit 31 clear to a PLL word stores the data exactly as written, including a 0 in bit 28.
- R4: Bit 16 of the word at 0xF4 always reads 0, whatever is written. The other bits of that word are stored as written.
- R5: A read at byte offset 0x308 or above, up to 0x3FC, returns 0.
- R6: A write at byte offset 0x308 or above changes no stored word.
- R7: In-window offsets with no named register (for example 0x04 and 0x238) reset to 0 and store any 32-bit value as written.
- R8: A write takes effect only when select, enable and write are all high. The written value is visible to a read in the following access. A setup phase without enable stores nothing.
- R9: Address bits 1:0 are ignored. An access at offset 4k+n (n = 1..3) reaches the word at 4k.
- R10: Named registers that are not PLL controls or the memory clock word (for example 0x50 and 0xFC) store every bit as written, with no lock insertion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte offset in the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data; 0 when not selected or out of range |

## Verification
The bench writes PLL words with the enable bit set and clear. A design that sets the lock flag too eagerly, or never sets it, returns a wrong bit 28. It writes all ones to the memory clock word, where a design that forgets to clear the update bit reads back 0x00010000 too much. Writes to the tail of the window are followed by a sweep of every implemented word, which catches an index that wraps or aliases into real registers. Setup-only cycles and accesses with low address bits set expose a design that strobes writes too early or decodes the byte offset without dropping the two low bits.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  localparam int unsigned DATA_W        = 32;
  localparam int unsigned PLL_EN_BIT    = 31;
  localparam int unsigned PLL_LOCK_BIT  = 28;
  localparam int unsigned MEMCLK_OFF    = 'h0F4;
  localparam int unsigned MEMCLK_UPD_BIT = 16;

  function automatic bit is_pll(input int unsigned off);
    case (off)
      'h000, 'h008, 'h010, 'h018, 'h020, 'h028, 'h038, 'h044, 'h048: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] reset_word(input int unsigned off);
    case (off)
      'h000, 'h020:                      return 32'h0000_1000;
      'h008:                             return 32'h0003_5514;
      'h010, 'h018, 'h038, 'h048:        return 32'h0300_6207;
      'h028, 'h044:                      return 32'h0004_1811;
      'h050:                             return 32'h0001_0000;
      'h054:                             return 32'h0000_1010;
      'h058:                             return 32'h0100_0000;
      'h0FC:                             return 32'h8000_0000;
      'h200, 'h204:                      return 32'h0000_00FF;
      'h220:                             return 32'h0810_0200;
      'h230:                             return 32'h8110_4000;
      'h234, 'h244:                      return 32'h1010_0010;
      'h224, 'h228, 'h22C, 'h23C, 'h248: return 32'h1010_0000;
      'h250:                             return 32'h0A10_1000;
      'h260:                             return 32'h1488_0000;
      default:                           return '0;
    endcase
  endfunction
endpackage

// File: rtl/clkctl_decode.sv
module clkctl_decode #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned NWORDS = 194,
  parameter int unsigned IDX_W  = 8
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output logic              in_range,
  output logic [IDX_W-1:0]  idx,
  output logic [NWORDS-1:0] we
);
  localparam int unsigned WA_W = ADDR_W - 2;

  logic [WA_W-1:0] word_addr;
  logic            fire;

  assign word_addr = paddr[ADDR_W-1:2];
  assign in_range  = 32'(word_addr) < 32'(NWORDS);
  assign idx       = IDX_W'(word_addr);
  assign fire      = psel & penable & pwrite & in_range;

  for (genvar i = 0; i < NWORDS; i++) begin : g_we
    assign we[i] = fire && (idx == IDX_W'(i));
  end
endmodule

// File: rtl/clkctl_shaper.sv
module clkctl_shaper #(
  parameter int unsigned IDX_W = 8
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [31:0]      din,
  output logic [31:0]      dout
);
  import clkctl_pkg::*;

  always_comb begin
    dout = din;
    if (is_pll(32'(idx) * 4) && din[PLL_EN_BIT]) dout[PLL_LOCK_BIT] = 1'b1;
    if (32'(idx) * 4 == MEMCLK_OFF) dout[MEMCLK_UPD_BIT] = 1'b0;
  end
endmodule

// File: rtl/clkctl_store.sv
module clkctl_store #(
  parameter int unsigned NWORDS = 194,
  parameter int unsigned IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NWORDS-1:0] we,
  input  logic [31:0]       wdata,
  input  logic              rvld,
  input  logic [IDX_W-1:0]  ridx,
  output logic [31:0]       rdata
);
  import clkctl_pkg::*;

  logic [31:0] q [NWORDS];

  for (genvar i = 0; i < NWORDS; i++) begin : g_word
    localparam logic [31:0] RV = reset_word(i * 4);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q[i] <= RV;
      else if (we[i]) q[i] <= wdata;
    end

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !we[i] |=> $stable(q[i]));

    if (is_pll(i * 4)) begin : g_pll
      assert_lock_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we[i] && wdata[PLL_EN_BIT]) |=> q[i][PLL_LOCK_BIT]);
    end
    if (i * 4 == MEMCLK_OFF) begin : g_memclk
      assert_upd_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !q[i][MEMCLK_UPD_BIT]);
    end
  end

  assert_one_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(we));

  always_comb begin
    rdata = '0;
    if (rvld && 32'(ridx) < 32'(NWORDS)) rdata = q[ridx];
  end
endmodule

// File: rtl/clkctl_regs.sv
module clkctl_regs #(
  parameter int unsigned ADDR_W     = 10,
  parameter int unsigned IMPL_BYTES = 'h308
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata
);
  localparam int unsigned NWORDS = IMPL_BYTES / 4;
  localparam int unsigned IDX_W  = $clog2(NWORDS);

  logic              in_range;
  logic [IDX_W-1:0]  idx;
  logic [NWORDS-1:0] we;
  logic [31:0]       shaped;

  clkctl_decode #(.ADDR_W(ADDR_W), .NWORDS(NWORDS), .IDX_W(IDX_W)) u_decode (
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .in_range(in_range), .idx(idx), .we(we)
  );

  clkctl_shaper #(.IDX_W(IDX_W)) u_shaper (
    .idx(idx), .din(pwdata), .dout(shaped)
  );

  clkctl_store #(.NWORDS(NWORDS), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we(we), .wdata(shaped),
    .rvld(psel && !pwrite && in_range), .ridx(idx), .rdata(prdata)
  );

  assert_tail_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && 32'(paddr) >= 32'(IMPL_BYTES)) |-> (prdata == '0));

  assert_tail_write_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && pwrite && 32'(paddr) >= 32'(IMPL_BYTES)) |-> (we == '0));

  assert_setup_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !penable |-> (we == '0));
endmodule

// File: tb/clkctl_regs_bench.sv
module clkctl_regs_bench;
  localparam int NW = 194;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [9:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] model [NW];

  always #5 clk = ~clk;

  clkctl_regs u_clkctl_regs (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata)
  );

  function automatic logic [31:0] rv(input int off);
    case (off)
      'h000, 'h020: return 32'h0000_1000;
      'h008: return 32'h0003_5514;
      'h010, 'h018, 'h038, 'h048: return 32'h0300_6207;
      'h028, 'h044: return 32'h0004_1811;
      'h050: return 32'h0001_0000;
      'h054: return 32'h0000_1010;
      'h058: return 32'h0100_0000;
      'h0FC: return 32'h8000_0000;
      'h200, 'h204: return 32'h0000_00FF;
      'h220: return 32'h0810_0200;
      'h230: return 32'h8110_4000;
      'h234, 'h244: return 32'h1010_0010;
      'h224, 'h228, 'h22C, 'h23C, 'h248: return 32'h1010_0000;
      'h250: return 32'h0A10_1000;
      'h260: return 32'h1488_0000;
      default: return 32'h0;
    endcase
  endfunction

  function automatic bit pll_off(input int off);
    return off == 'h00 || off == 'h08 || off == 'h10 || off == 'h18 || off == 'h20 ||
           off == 'h28 || off == 'h38 || off == 'h44 || off == 'h48;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    int w;
    logic [31:0] v;
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    w = int'(a) / 4;
    if (w < NW) begin
      v = d;
      if (pll_off(w * 4) && d[31]) v[28] = 1'b1;
      if (w * 4 == 'hF4) v[16] = 1'b0;
      model[w] = v;
    end
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1; #1 d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int w = 0; w < NW; w++) begin
      rd(10'(w * 4), d);
      chk("R1 reset value", d, rv(w * 4));
    end
    rd(10'h004, d); chk("R7 unnamed resets to 0", d, 32'h0);
    rd(10'h238, d); chk("R7 unnamed resets to 0", d, 32'h0);
  endtask

  task automatic t_pll_enable;
    logic [31:0] d;
    wr(10'h000, 32'h8000_0011); rd(10'h000, d); chk("R2 lock set", d, 32'h9000_0011);
    wr(10'h048, 32'hA5A5_0000); rd(10'h048, d); chk("R2 lock set", d, 32'hB5A5_0000);
    wr(10'h044, 32'h9000_1234); rd(10'h044, d); chk("R2 lock already set", d, 32'h9000_1234);
  endtask

  task automatic t_pll_disabled;
    logic [31:0] d;
    wr(10'h010, 32'h0000_7777); rd(10'h010, d); chk("R3 stored as written", d, 32'h0000_7777);
    wr(10'h038, 32'h1000_0001); rd(10'h038, d); chk("R3 lock bit kept as written", d, 32'h1000_0001);
    wr(10'h000, 32'h0000_0000); rd(10'h000, d); chk("R3 lock cleared", d, 32'h0);
  endtask

  task automatic t_memclk;
    logic [31:0] d;
    wr(10'h0F4, 32'hFFFF_FFFF); rd(10'h0F4, d); chk("R4 update bit clear", d, 32'hFFFE_FFFF);
    wr(10'h0F4, 32'h0001_0005); rd(10'h0F4, d); chk("R4 update bit clear", d, 32'h0000_0005);
  endtask

  task automatic t_tail_read;
    logic [31:0] d;
    rd(10'h308, d); chk("R5 tail reads 0", d, 32'h0);
    rd(10'h3FC, d); chk("R5 tail reads 0", d, 32'h0);
  endtask

  task automatic t_tail_write;
    logic [31:0] d;
    wr(10'h308, 32'hDEAD_BEEF);
    wr(10'h30C, 32'hCAFE_F00D);
    wr(10'h3FC, 32'h1234_5678);
    rd(10'h308, d); chk("R6 tail write dropped", d, 32'h0);
    for (int w = 0; w < NW; w++) begin
      rd(10'(w * 4), d);
      chk("R6 no word touched by tail write", d, model[w]);
    end
  endtask

  task automatic t_plain;
    logic [31:0] d;
    wr(10'h004, 32'h5A5A_A5A5); rd(10'h004, d); chk("R7 plain storage", d, 32'h5A5A_A5A5);
    wr(10'h238, 32'hFFFF_FFFF); rd(10'h238, d); chk("R7 plain storage", d, 32'hFFFF_FFFF);
  endtask

  task automatic t_setup_only;
    logic [31:0] d;
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = 10'h004; pwdata = 32'h0BAD_0BAD;
    @(negedge clk); psel = 0; pwrite = 0;
    rd(10'h004, d); chk("R8 setup phase stores nothing", d, model[1]);
    wr(10'h100, 32'h1357_9BDF); rd(10'h100, d); chk("R8 write visible next access", d, 32'h1357_9BDF);
  endtask

  task automatic t_low_bits;
    logic [31:0] d;
    wr(10'h00A, 32'h0000_2468); rd(10'h008, d); chk("R9 low bits ignored on write", d, 32'h0000_2468);
    rd(10'h00B, d); chk("R9 low bits ignored on read", d, 32'h0000_2468);
  endtask

  task automatic t_non_pll;
    logic [31:0] d;
    wr(10'h050, 32'h8000_0000); rd(10'h050, d); chk("R10 no lock insertion", d, 32'h8000_0000);
    wr(10'h0FC, 32'h8001_0000); rd(10'h0FC, d); chk("R10 stored as written", d, 32'h8001_0000);
  endtask

  initial begin
    for (int w = 0; w < NW; w++) model[w] = rv(w * 4);
    repeat (3) @(negedge clk);
    #1 chk("R5 idle output 0", prdata, 32'h0);
    rst_n = 1'b1;
    t_reset();
    t_pll_enable();
    t_pll_disabled();
    t_memclk();
    t_tail_read();
    t_plain();
    t_setup_only();
    t_low_bits();
    t_non_pll();
    t_tail_write();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule